// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 16-bit interval timer that counts down once per timer tick and signals software when the count passes through zero. Software programs it through a small synchronous register bus. There are three registers: a control word, a modulus and a read-only live count. The tick is either the input clock itself or the input clock divided by 64.

Two uses are intended. In periodic use, the reload bit makes the counter refill from the modulus after it reaches zero. This produces an event every modulus+1 ticks. In one-shot use, the overwrite bit makes every modulus write load the counter at once and restart the prescaler, so each write begins a fresh interval. The event flag is sticky. It is cleared by writing a one to its bit, and it drives the interrupt line when the interrupt enable bit is set.

Top module: `ivl_timer`

## Requirements
- R1: After reset the control word reads 0, the modulus and the counter read 0xFFFF, the interrupt output is low and the read data is 0.
- R2: The register map uses byte offsets 0x0 for control, 0x2 for modulus and 0x4 for counter. Control bit 0 is run, bit 1 is reload, bit 2 is the event flag, bit 3 is interrupt enable, bit 4 is overwrite and bit 5 is divide-by-64. The other control bits and any unmapped offset read 0. Read data appears on the clock edge after the address is presented and shows the state before that edge.
- R3: While run is 0, no ticks occur and the counter holds its value, except when an overwrite load changes it.
- R4: With reload set, a tick at count 0 loads the modulus, so the period is modulus+1 ticks.
- R5: The flag sets on the tick that moves the counter from 1 to 0, and it stays set until software clears it.
- R6: With reload clear, a tick at count 0 wraps the counter to 0xFFFF and counting continues.
- R7: A modulus write with overwrite set loads the written value into the counter on that edge and restarts the prescaler. With overwrite clear, a modulus write leaves the counter unchanged.
- R8: With divide-by-64 clear, every clock is a tick while running. With it set, a tick comes every 64 clocks, the first one 64 clocks after run starts or after an overwrite load. The prescaler resets while run is 0.
- R9: Writing control with bit 2 at 1 clears the flag, and writing 0 there leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R10: The interrupt output equals the flag ANDed with interrupt enable.
- R11: Writes to the counter offset are ignored. Reading the counter does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model in the bench tracks the counter, the prescaler and the flag, and the bench compares read data and the interrupt output against it on every cycle. The stimulus covers:
- a short periodic modulus, which separates the reload path from the wrap path;
- a free-running wrap without reload;
- divide-by-64 runs, which expose prescaler phase and restart errors;
- modulus writes during counting with overwrite on and off.

A modulus of 1 with a flag clear written on every cycle forces set and clear onto the same edge, which tests the set-wins priority. Fixed-value reads with the timer stopped check the reset state, the bit layout and the ignored counter writes.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    // Control word bit positions (software-visible layout)
    localparam int RUN_B    = 0;
    localparam int RELOAD_B = 1;
    localparam int FLAG_B   = 2;
    localparam int IE_B     = 3;
    localparam int OVW_B    = 4;
    localparam int DIV_B    = 5;

    // Register byte offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_MOD  = 2;
    localparam int OFS_CNT  = 4;

    typedef struct packed {
        logic div64;
        logic ovw;
        logic ie;
        logic reload;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_sel,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || restart || !div_sel) begin
            st_d.phase = '0;
        end else if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        tick = run && (!div_sel || (st_q.phase == LAST));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.phase == '0)); // R8

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R3

endmodule

// File: rtl/ivl_counter.sv
module ivl_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] mod_val,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         flag
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         flag;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit_zero;

    always_comb begin
        st_d     = st_q;
        hit_zero = tick && (st_q.cnt == ONE);

        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload ? mod_val : '1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end

        // set has priority over a same-edge clear
        st_d.flag = hit_zero || (st_q.flag && !flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign flag  = st_q.flag;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(st_q.cnt)); // R3

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && reload && st_q.cnt == '0) |=> (st_q.cnt == $past(mod_val))); // R4

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == ONE) |=> st_q.flag); // R5

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !reload && st_q.cnt == '0) |=> (st_q.cnt == '1)); // R6

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(load_val))); // R7

    AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && st_q.cnt == ONE)) |=> !st_q.flag); // R9

endmodule

// File: rtl/ivl_regs.sv
module ivl_regs
    import ivl_timer_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  count,
    input  logic          flag,
    output ctrl_t         ctrl,
    output logic [W-1:0]  modulus,
    output logic          mod_load,
    output logic          flag_clr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_MOD  = AW'(OFS_MOD);
    localparam logic [AW-1:0] A_CNT  = AW'(OFS_CNT);

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] modulus;
        logic [W-1:0] rdata;
    } reg_st_t;

    reg_st_t      st_d, st_q;
    logic         wr_ctrl;
    logic         wr_mod;
    logic [W-1:0] ctrl_word;

    always_comb begin
        st_d    = st_q;
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_mod  = bus_we && (bus_addr == A_MOD);

        ctrl_word           = '0;
        ctrl_word[RUN_B]    = st_q.ctrl.run;
        ctrl_word[RELOAD_B] = st_q.ctrl.reload;
        ctrl_word[FLAG_B]   = flag;
        ctrl_word[IE_B]     = st_q.ctrl.ie;
        ctrl_word[OVW_B]    = st_q.ctrl.ovw;
        ctrl_word[DIV_B]    = st_q.ctrl.div64;

        if (wr_ctrl) begin
            st_d.ctrl.run    = bus_wdata[RUN_B];
            st_d.ctrl.reload = bus_wdata[RELOAD_B];
            st_d.ctrl.ie     = bus_wdata[IE_B];
            st_d.ctrl.ovw    = bus_wdata[OVW_B];
            st_d.ctrl.div64  = bus_wdata[DIV_B];
        end
        if (wr_mod) begin
            st_d.modulus = bus_wdata;
        end

        unique case (bus_addr)
            A_CTRL:  st_d.rdata = ctrl_word;
            A_MOD:   st_d.rdata = st_q.modulus;
            A_CNT:   st_d.rdata = count;
            default: st_d.rdata = '0;
        endcase

        mod_load = wr_mod && st_q.ctrl.ovw;
        flag_clr = wr_ctrl && bus_wdata[FLAG_B];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl    <= '0;
            st_q.modulus <= '1;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign modulus = st_q.modulus;
    assign rdata   = st_q.rdata;

    AST_MOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MOD) |=> (st_q.modulus == $past(bus_wdata))); // R2

    AST_CNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CNT) |=> (st_q.rdata == $past(count))); // R11

    AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CNT) |=> ($stable(st_q.modulus) && $stable(st_q.ctrl))); // R11

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int W   = 16,
    parameter int AW  = 3,
    parameter int DIV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          irq
);
    ctrl_t        ctrl;
    logic [W-1:0] modulus;
    logic [W-1:0] count;
    logic         mod_load;
    logic         flag_clr;
    logic         flag;
    logic         tick;

    ivl_regs #(.W(W), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .count     (count),
        .flag      (flag),
        .ctrl      (ctrl),
        .modulus   (modulus),
        .mod_load  (mod_load),
        .flag_clr  (flag_clr),
        .rdata     (bus_rdata)
    );

    ivl_prescaler #(.DIV(DIV)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .div_sel (ctrl.div64),
        .restart (mod_load),
        .tick    (tick)
    );

    ivl_counter #(.W(W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reload   (ctrl.reload),
        .load     (mod_load),
        .load_val (bus_wdata),
        .mod_val  (modulus),
        .flag_clr (flag_clr),
        .count    (count),
        .flag     (flag)
    );

    assign irq = flag && ctrl.ie;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.ie |-> !irq); // R10

endmodule

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    ivl_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    int m_run, m_rld, m_ie, m_ovw, m_div, m_flag, m_mod, m_cnt, m_pre, m_rd;

    always @(posedge clk) begin
        int tk, ld, nf, nc, np, rd, a, d;
        if (!rst_n) begin
            m_run = 0; m_rld = 0; m_ie = 0; m_ovw = 0; m_div = 0;
            m_flag = 0; m_mod = 65535; m_cnt = 65535; m_pre = 0; m_rd = 0;
        end else begin
            a  = int'(bus_addr);
            d  = int'(bus_wdata);
            tk = (m_run != 0) && (m_div == 0 || m_pre == 63);
            ld = bus_we && a == 2 && m_ovw != 0;
            case (a)
                0: rd = m_run | (m_rld << 1) | (m_flag << 2) | (m_ie << 3) | (m_ovw << 4) | (m_div << 5);
                2: rd = m_mod;
                4: rd = m_cnt;
                default: rd = 0;
            endcase
            nf = m_flag;
            if (bus_we && a == 0 && d[2]) nf = 0;
            if (tk && m_cnt == 1) nf = 1;
            nc = m_cnt;
            if (ld) nc = d;
            else if (tk) nc = (m_cnt == 0) ? (m_rld ? m_mod : 65535) : m_cnt - 1;
            np = (m_run == 0 || ld || m_div == 0) ? 0 : (m_pre == 63 ? 0 : m_pre + 1);
            if (bus_we && a == 0) begin
                m_run = d[0]; m_rld = d[1]; m_ie = d[3]; m_ovw = d[4]; m_div = d[5];
            end
            if (bus_we && a == 2) m_mod = d;
            m_flag = nf; m_cnt = nc; m_pre = np; m_rd = rd;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(bus_rdata) != m_rd || int'(irq) != (m_flag & m_ie)) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%0d expected rdata=%h irq=%0d",
                         phase, bus_rdata, irq, m_rd[15:0], m_flag & m_ie);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd4;
    endtask

    task automatic chk_rd(input int a, input int exp, input string req);
        @(negedge clk);
        bus_addr = 3'(a);
        @(negedge clk);
        checks++;
        if (int'(bus_rdata) != exp) begin
            errors++;
            $display("FAIL %s: offset %0d read %h expected %h", req, a, bus_rdata, exp[15:0]);
        end
        bus_addr = 3'd4;
    endtask

    task automatic chk_irq(input int exp, input string req);
        @(negedge clk);
        checks++;
        if (int'(irq) != exp) begin
            errors++;
            $display("FAIL %s: irq=%0d expected %0d", req, irq, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        chk_irq(0, "R1");
        chk_rd(0, 16'h0000, "R1");
        chk_rd(2, 16'hFFFF, "R1");
        chk_rd(4, 16'hFFFF, "R1");

        phase = "R2";
        chk_rd(6, 0, "R2");
        wr(0, 16'hFFF8);                 // all writable bits except run/reload/flag
        chk_rd(0, 16'h0038, "R2");

        phase = "R7";
        wr(0, 16'h0010);                 // overwrite only, stopped
        wr(2, 5);
        chk_rd(4, 5, "R7");
        wr(0, 16'h0000);
        wr(2, 9);
        chk_rd(4, 5, "R7");
        chk_rd(2, 9, "R7");

        phase = "R11";
        wr(4, 16'h1234);
        chk_rd(4, 5, "R11");
        chk_rd(2, 9, "R11");

        phase = "R3";
        idle(20);
        chk_rd(4, 5, "R3");

        // periodic, every clock is a tick
        phase = "R4";
        wr(0, 16'h0010);
        wr(2, 3);
        wr(0, 16'h000B);                 // run | reload | ie
        idle(30);
        phase = "R10";
        chk_irq(1, "R10");
        wr(0, 16'h0008);                 // stop, flag bit written 0
        phase = "R9";
        idle(5);
        chk_irq(1, "R9");
        wr(0, 16'h000C);                 // clear flag
        chk_irq(0, "R9");
        wr(0, 16'h0000);
        wr(0, 16'h0004);
        chk_irq(0, "R10");

        // wrap without reload
        phase = "R6";
        wr(0, 16'h0010);
        wr(2, 2);
        wr(0, 16'h0009);                 // run | ie
        idle(12);
        wr(0, 16'h0000);
        chk_rd(4, m_cnt, "R6");
        wr(0, 16'h0004);

        // divide by 64
        phase = "R8";
        wr(0, 16'h0010);
        wr(2, 2);
        wr(0, 16'h002B);                 // run | reload | ie | div64
        idle(450);
        wr(0, 16'h0000);
        idle(5);
        wr(0, 16'h0024);                 // clear flag, keep div
        wr(0, 16'h0021);                 // restart divided count
        idle(200);
        wr(0, 16'h0000);

        // one-shot style overwrite while running
        phase = "R7";
        wr(0, 16'h0004);
        wr(0, 16'h0039);                 // run | ie | ovw | div64
        wr(2, 3);
        idle(100);
        wr(2, 2);
        idle(150);
        wr(0, 16'h0019);                 // undivided
        wr(2, 7);
        idle(4);
        wr(2, 1);
        idle(10);
        wr(0, 16'h0000);

        // set/clear collision with modulus 1 reloading each other tick
        phase = "R9";
        wr(0, 16'h0010);
        wr(2, 1);
        wr(0, 16'h000B);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bus_addr = 3'd0; bus_we = 1'b1; bus_wdata = 16'h000F;
        end
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd4;
        idle(6);

        phase = "R11";
        for (int i = 0; i < 8; i++) begin
            wr(4, 16'hA5A5);
            idle(2);
        end
        wr(0, 16'h0000);
        chk_rd(4, m_cnt, "R11");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule